// File: doc/BRIEF.md
# Status Register and Write-Protect Guard

This block keeps the status byte of a serial nonvolatile memory and rules on every write the rest of the chip wants to make. It holds the write-enable latch, a two-bit block-protect field and a protect-enable bit, and combines them with the external active-low write-protect pin. From these it produces the status byte for status reads, a flag that says whether the array address now presented is protected, and a flag that says whether a status-register load would be accepted.

The serial front end reports each frame once the chip select rises. It passes on the opcode, the number of bits clocked in and the last data byte. This block classifies the frame itself, so the rule that only a complete frame of the right length counts is enforced here. The page controller supplies the write-in-progress flag and a one-cycle pulse when a self-timed write cycle ends. Serial shifting and array storage are handled elsewhere.

Top module: `sr_status_guard`

## Requirements
- R1: After reset the status byte reads 0x00, the latch and all stored protection bits are clear, `arr_prot` is 1 and `sr_wr_ok` is 0.
- R2: The status byte holds the protect-enable bit at bit 7, reads 0 at bits 6:4, holds the block-protect field at bits 3:2 and the write-enable latch at bit 1. Bit 0 shows `wip_in` as sampled at the previous clock edge. A status load stores only bits 7, 3 and 2 of its data byte.
- R3: For block-protect 00 no address is protected. For 01 the top quarter (0x300 to 0x3FF) is protected, for 10 the top half (0x200 to 0x3FF), and for 11 every address.
- R4: While the write-enable latch is clear, `arr_prot` is 1 for every address and `sr_wr_ok` is 0.
- R5: `sr_wr_ok` is 1 exactly when the latch is set and either the protect-enable bit is 0 or the synchronised `wprot_n` is high. A change on `wprot_n` reaches `sr_wr_ok` after two clock edges.
- R6: The latch is set only by a frame with opcode 0x06 and a bit count of exactly 8. The same opcode with any other count has no effect. The latch is set even while the status register is locked by the pin.
- R7: The latch is cleared by a frame with opcode 0x04 and exactly 8 bits, or by a `cycle_done` pulse. If a set frame and `cycle_done` arrive in the same cycle, the set wins.
- R8: A frame with opcode 0x01 and exactly 16 bits loads the stored bits only if `sr_wr_ok` is 1 at that edge. A locked or wrongly sized load changes nothing, and frames with any other opcode leave the status byte as it was.
- R9: Once a load is accepted, `wprot_n` falling afterwards does not undo it. The latch stays set until `cycle_done`.
- R10: `status_byte` and `sr_wr_ok` reflect a frame one clock edge after the edge that samples `cs_rise`. `arr_prot` is registered: it gives the verdict for the `qry_addr` presented at an edge, using the state as it stands after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_rise | input | 1 | One-cycle pulse: a frame ended with chip select rising |
| frame_op | input | 8 | Opcode of the ended frame |
| frame_bits | input | BW (10) | Number of bits clocked in during the frame |
| frame_data | input | 8 | Last data byte of the frame |
| cycle_done | input | 1 | One-cycle pulse: a self-timed write cycle finished |
| wip_in | input | 1 | Write-in-progress flag from the page controller |
| wprot_n | input | 1 | Asynchronous write-protect pin, active low |
| qry_addr | input | AW (10) | Array address to be judged |
| status_byte | output | 8 | Status byte for reads |
| arr_prot | output | 1 | The queried address may not be written |
| sr_wr_ok | output | 1 | A status load would be accepted now |

## Verification
Every frame, cycle-done pulse and address query is due one edge after the edge that samples it, and the write-protect pin is due two edges later. The driver applies each stimulus on a falling edge. With it, the driver queues the expected status byte, protect flag and permission, stamped with the cycle count of the next falling edge. The monitor compares only items whose stamp matches the current cycle. For pin changes, the step that drives the pin still expects the old permission, and the following step expects the new one.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
  localparam logic [7:0] OP_SET_WEL = 8'h06;
  localparam logic [7:0] OP_CLR_WEL = 8'h04;
  localparam logic [7:0] OP_LOAD_SR = 8'h01;
  // stored (nonvolatile) bits of the status byte: enable bit 7, block field 3:2
  localparam logic [7:0] NV_MASK    = 8'h8C;
  localparam int unsigned POS_PEN   = 7;
  localparam int unsigned POS_BPH   = 3;
  localparam int unsigned POS_BPL   = 2;

  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_SET_WEL = 2'd1,
    EV_CLR_WEL = 2'd2,
    EV_LOAD_SR = 2'd3
  } frame_ev_e;
endpackage

// File: rtl/sr_wp_sync.sv
module sr_wp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sr_frame_decode.sv
module sr_frame_decode
  import sr_guard_pkg::*;
#(
  parameter int BW = 10
) (
  input  logic          cs_rise,
  input  logic [7:0]    frame_op,
  input  logic [BW-1:0] frame_bits,
  output frame_ev_e     ev
);
  localparam logic [BW-1:0] LEN_CMD = BW'(8);
  localparam logic [BW-1:0] LEN_SR  = BW'(16);

  always_comb begin
    ev = EV_NONE;
    if (cs_rise) begin
      if (frame_op == OP_SET_WEL && frame_bits == LEN_CMD)      ev = EV_SET_WEL;
      else if (frame_op == OP_CLR_WEL && frame_bits == LEN_CMD) ev = EV_CLR_WEL;
      else if (frame_op == OP_LOAD_SR && frame_bits == LEN_SR)  ev = EV_LOAD_SR;
    end
  end
endmodule

// File: rtl/sr_prot_lookup.sv
module sr_prot_lookup #(
  parameter int AW = 10
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    bp,
  input  logic          wel,
  output logic          prot
);
  localparam logic [AW-1:0] QTR_BASE  = {2'b11, {(AW-2){1'b0}}};
  localparam logic [AW-1:0] HALF_BASE = {1'b1,  {(AW-1){1'b0}}};

  always_comb begin
    unique case (bp)
      2'b00:   prot = 1'b0;
      2'b01:   prot = (addr >= QTR_BASE);
      2'b10:   prot = (addr >= HALF_BASE);
      default: prot = 1'b1;
    endcase
    if (!wel) prot = 1'b1;
  end
endmodule

// File: rtl/sr_status_guard.sv
module sr_status_guard
  import sr_guard_pkg::*;
#(
  parameter int AW   = 10,
  parameter int BW   = 10,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_rise,
  input  logic [7:0]    frame_op,
  input  logic [BW-1:0] frame_bits,
  input  logic [7:0]    frame_data,
  input  logic          cycle_done,
  input  logic          wip_in,
  input  logic          wprot_n,
  input  logic [AW-1:0] qry_addr,
  output logic [7:0]    status_byte,
  output logic          arr_prot,
  output logic          sr_wr_ok
);
  frame_ev_e  ev;
  logic       wp_s;
  logic       wel_q, wel_d;
  logic       wip_q;
  logic [7:0] nv_q, nv_d;
  logic       ok_now;
  logic       prot_d;
  logic       arr_prot_q;

  sr_frame_decode #(.BW(BW)) u_dec (
    .cs_rise   (cs_rise),
    .frame_op  (frame_op),
    .frame_bits(frame_bits),
    .ev        (ev)
  );

  sr_wp_sync #(.STAGES(SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (wprot_n),
    .dout(wp_s)
  );

  assign ok_now = wel_q & (~nv_q[POS_PEN] | wp_s);

  always_comb begin
    wel_d = wel_q;
    if (ev == EV_SET_WEL)      wel_d = 1'b1;
    else if (ev == EV_CLR_WEL) wel_d = 1'b0;
    else if (cycle_done)       wel_d = 1'b0;
  end

  always_comb begin
    nv_d = nv_q;
    if (ev == EV_LOAD_SR && ok_now) nv_d = frame_data & NV_MASK;
  end

  sr_prot_lookup #(.AW(AW)) u_lookup (
    .addr(qry_addr),
    .bp  (nv_d[POS_BPH:POS_BPL]),
    .wel (wel_d),
    .prot(prot_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q      <= 1'b0;
      wip_q      <= 1'b0;
      nv_q       <= 8'h00;
      arr_prot_q <= 1'b1;
    end else begin
      wel_q      <= wel_d;
      wip_q      <= wip_in;
      nv_q       <= nv_d;
      arr_prot_q <= prot_d;
    end
  end

  assign status_byte = nv_q | {6'b0, wel_q, wip_q};
  assign arr_prot    = arr_prot_q;
  assign sr_wr_ok    = ok_now;

  AST_WEL_SET_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(wel_q) |-> $past(ev == EV_SET_WEL)); // R6
  AST_WEL_CLR_SRC: assert property (@(posedge clk) disable iff (rst)
    $fell(wel_q) |-> $past((ev == EV_CLR_WEL) || cycle_done) && !$past(ev == EV_SET_WEL)); // R7
  AST_SR_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !$stable(nv_q) |-> $past(ev == EV_LOAD_SR && ok_now)); // R8
  AST_NOWEL_PROT: assert property (@(posedge clk) disable iff (rst)
    !wel_q |-> arr_prot && !sr_wr_ok); // R4
  AST_ALL_PROT: assert property (@(posedge clk) disable iff (rst)
    (status_byte[3:2] == 2'b11) |-> arr_prot); // R3
  AST_WIP_MIRROR: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> status_byte[0] == $past(wip_in)); // R2
endmodule

// File: tb/sr_status_guard_bench.sv
module sr_status_guard_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_rise = 1'b0;
  logic [7:0] frame_op = 8'h00;
  logic [9:0] frame_bits = 10'd0;
  logic [7:0] frame_data = 8'h00;
  logic       cycle_done = 1'b0;
  logic       wip_in = 1'b0;
  logic       wprot_n = 1'b1;
  logic [9:0] qry_addr = 10'd0;
  logic [7:0] status_byte;
  logic       arr_prot;
  logic       sr_wr_ok;

  always #2 clk = ~clk;

  sr_status_guard u_sr_status_guard (
    .clk(clk), .rst(rst), .cs_rise(cs_rise), .frame_op(frame_op),
    .frame_bits(frame_bits), .frame_data(frame_data), .cycle_done(cycle_done),
    .wip_in(wip_in), .wprot_n(wprot_n), .qry_addr(qry_addr),
    .status_byte(status_byte), .arr_prot(arr_prot), .sr_wr_ok(sr_wr_ok)
  );

  typedef struct packed {
    logic [31:0] due;
    logic [7:0]  st;
    logic        p;
    logic        ok;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    cyc = 0;
  int    total = 0;
  int    fails = 0;
  bit    finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // monitor: pops every item due on this falling edge
  always @(negedge clk) begin
    while (expq.size() > 0 && expq[0].due == cyc) begin
      exp_t  e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      total++;
      if (status_byte !== e.st || arr_prot !== e.p || sr_wr_ok !== e.ok) begin
        fails++;
        $display("FAIL %s: got st=%02h prot=%b ok=%b, expected st=%02h prot=%b ok=%b",
                 t, status_byte, arr_prot, sr_wr_ok, e.st, e.p, e.ok);
      end
    end
  end

  task automatic step(input logic ev, input logic [7:0] op, input int bits,
                      input logic [7:0] data, input logic done, input logic wip,
                      input logic wpn, input logic [9:0] addr,
                      input logic [7:0] est, input logic ep, input logic eok,
                      input string tag);
    exp_t e;
    @(negedge clk);
    cs_rise = ev; frame_op = op; frame_bits = bits[9:0]; frame_data = data;
    cycle_done = done; wip_in = wip; wprot_n = wpn; qry_addr = addr;
    e.due = cyc + 1; e.st = est; e.p = ep; e.ok = eok;
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    //   ev  op     bits data   done wip wpn addr    st     p  ok
    step(0, 8'h00, 0,  8'h00, 0, 0, 1, 10'h000, 8'h00, 1, 0, "R1 reset state");
    step(1, 8'h06, 8,  8'h00, 0, 0, 1, 10'h000, 8'h02, 0, 1, "R6 set latch");
    step(1, 8'h04, 8,  8'h00, 0, 0, 1, 10'h000, 8'h00, 1, 0, "R7 clear latch; R4");
    step(1, 8'h06, 16, 8'h00, 0, 0, 1, 10'h000, 8'h00, 1, 0, "R6 long frame ignored");
    step(1, 8'h06, 7,  8'h00, 0, 0, 1, 10'h000, 8'h00, 1, 0, "R6 short frame ignored");
    step(1, 8'h06, 8,  8'h00, 0, 0, 1, 10'h3FF, 8'h02, 0, 1, "R3 none protected");
    step(1, 8'h01, 16, 8'h84, 0, 1, 1, 10'h3FF, 8'h87, 1, 1, "R8 load quarter; R10");
    step(0, 8'h00, 0,  8'h00, 0, 1, 0, 10'h2FF, 8'h87, 0, 1, "R3 below quarter; R5 lag");
    step(0, 8'h00, 0,  8'h00, 0, 1, 0, 10'h300, 8'h87, 1, 0, "R9 pin low keeps load; R5");
    step(0, 8'h00, 0,  8'h00, 1, 0, 0, 10'h000, 8'h84, 1, 0, "R7 cycle done clears");
    step(1, 8'h06, 8,  8'h00, 0, 0, 0, 10'h000, 8'h86, 0, 0, "R6 set while locked");
    step(1, 8'h01, 16, 8'h08, 0, 0, 0, 10'h200, 8'h86, 0, 0, "R8 locked load ignored");
    step(0, 8'h00, 0,  8'h00, 0, 0, 1, 10'h200, 8'h86, 0, 0, "R5 pin rise lag");
    step(0, 8'h00, 0,  8'h00, 0, 0, 1, 10'h200, 8'h86, 0, 1, "R5 pin high unlocks");
    step(1, 8'h01, 15, 8'h08, 0, 0, 1, 10'h200, 8'h86, 0, 1, "R8 short load ignored");
    step(1, 8'h01, 16, 8'h08, 0, 1, 1, 10'h200, 8'h0B, 1, 1, "R8 load half; R2 wip");
    step(0, 8'h00, 0,  8'h00, 0, 1, 1, 10'h1FF, 8'h0B, 0, 1, "R3 below half");
    step(0, 8'h00, 0,  8'h00, 1, 0, 1, 10'h1FF, 8'h08, 1, 0, "R9 latch held to done; R4");
    step(1, 8'h06, 8,  8'h00, 0, 0, 1, 10'h1FF, 8'h0A, 0, 1, "R6 set again");
    step(1, 8'h01, 16, 8'hFF, 0, 0, 1, 10'h000, 8'h8E, 1, 1, "R2 masked load; R3 all");
    step(0, 8'h00, 0,  8'h00, 1, 0, 1, 10'h000, 8'h8C, 1, 0, "R7 done after load");
    step(1, 8'h06, 8,  8'h00, 1, 0, 1, 10'h000, 8'h8E, 1, 1, "R7 set beats done");
    step(0, 8'h00, 0,  8'h00, 1, 0, 1, 10'h000, 8'h8C, 1, 0, "R7 write done clears");
    step(1, 8'h06, 8,  8'h00, 0, 0, 1, 10'h000, 8'h8E, 1, 1, "R6 set");
    step(1, 8'h02, 8,  8'h00, 0, 0, 1, 10'h000, 8'h8E, 1, 1, "R8 other opcode ignored");
    step(1, 8'h04, 9,  8'h00, 0, 0, 1, 10'h000, 8'h8E, 1, 1, "R7 long clear ignored");
    step(1, 8'h04, 8,  8'h00, 0, 0, 1, 10'h000, 8'h8C, 1, 0, "R7 clear frame");
    step(0, 8'h00, 0,  8'h00, 0, 0, 1, 10'h000, 8'h8C, 1, 0, "R10 idle holds");
    repeat (4) @(negedge clk);
    if (expq.size() != 0) begin
      total++; fails++;
      $display("FAIL R10: got %0d unchecked items, expected 0", expq.size());
    end
    finished = 1;
    report();
    $finish;
  end
endmodule